// File: doc/BRIEF.md
# Odd-Parity Bus Transceiver with Sticky Error Flag

This block links two byte-wide ports, side A and side B, under two active-low direction controls. When it drives side B from side A it also drives a ninth line, the parity bit, chosen so that the B bytes plus that bit carry an odd number of ones. When it drives side A from side B it checks that the incoming B bytes plus the incoming parity bit are odd. A diagnostic route drives A onto B but deliberately inverts the parity bit, so the checker can be tested from the system side. Each port is modelled as a separate input, data output and per-bit drive enable, and the surrounding bus logic resolves them.

The result of the parity check, called the check node, feeds an error flag. The flag drives an open-drain style pull-down output that is active while an error is shown. Two active-low controls choose the flag operation. Pass shows the check node directly. Sample latches any failure until it is released. Clear forces the no-error level. Store holds the last level shown.

The flag is a two-state machine with the states FLAG_CLEAN and FLAG_TRIPPED. On each rising clock edge the register loads the level shown during that cycle. The transitions are:
- Pass goes to FLAG_CLEAN or FLAG_TRIPPED, following the check node.
- Sample goes from FLAG_TRIPPED only to FLAG_TRIPPED. From FLAG_CLEAN it goes to FLAG_TRIPPED on a failing check.
- Clear always goes to FLAG_CLEAN.
- Store stays in the current state.

A synchronous active-low reset enters FLAG_CLEAN.

Top module: `par_xcvr`

## Requirements
- R1: With oeb_n=0 and oea_n=1 (route A2B), b_out equals a_in and every b_oe bit is 1. par_oe is 1 and par_out is 1 when a_in holds an even number of ones, 0 when odd. a_oe is all 0.
- R2: With oea_n=0 and oeb_n=1 (route B2A), a_out equals b_in and every a_oe bit is 1. b_oe is all 0 and par_oe is 0.
- R3: With oea_n=0 and oeb_n=0 (route DIAG), b_out equals a_in with every b_oe bit 1. par_oe is 1 and par_out is 1 when a_in has an odd count of ones. The check node then fails.
- R4: With oea_n=1 and oeb_n=1 (route ISOLATE), a_oe, b_oe and par_oe are all 0.
- R5: The check node passes when the B values plus the parity value hold an odd count of ones. These are the driven values when the block drives side B, and b_in and par_in otherwise. In ISOLATE the check node passes exactly when a_in has an odd count of ones.
- R6: With en_n=0 and clr_n=0 (pass), err_pull is 1 in the same cycle exactly when the check node fails.
- R7: With en_n=0 and clr_n=1 (sample), err_pull is 1 when the flag was tripped or the check node fails. Once tripped it stays 1 while sample continues.
- R8: With en_n=1 and clr_n=0 (clear), err_pull is 0, and the flag is clean in the next cycle.
- R9: With en_n=1 and clr_n=1 (store), err_pull keeps the value it had in the previous cycle.
- R10: After a synchronous reset (rst_n=0 over a rising edge) the flag is FLAG_CLEAN, so err_pull is 0 under store.
- R11: a_oe and b_oe are never both non-zero. par_oe is 1 only while all b_oe bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag |
| oea_n | input | 1 | Active-low drive control for side A |
| oeb_n | input | 1 | Active-low drive control for side B and parity |
| en_n | input | 1 | Active-low flag enable control |
| clr_n | input | 1 | Active-low flag clear control |
| a_in | input | WIDTH | Value present on side A |
| a_out | output | WIDTH | Data driven onto side A |
| a_oe | output | WIDTH | Per-bit drive enable for side A |
| b_in | input | WIDTH | Value present on side B |
| b_out | output | WIDTH | Data driven onto side B |
| b_oe | output | WIDTH | Per-bit drive enable for side B |
| par_in | input | 1 | Value present on the parity line |
| par_out | output | 1 | Parity value driven |
| par_oe | output | 1 | Drive enable for the parity line |
| err_pull | output | 1 | Pull-down enable of the error line; 1 shows an error |

## Verification
The hardest condition to reach is a latched failure that survives while the check node recovers. That takes a bad B word under sample, then good words under sample, then a switch to store, and only after that clear. The stimulus starts with this exact ordered sequence in the B2A route. It then checks the diagnostic route and the isolate route under pass. Long random runs follow that change route and flag operation every cycle, with a reset in the middle. A behavioural model tracks the expected flag level through all of it.

// File: rtl/par_xcvr_pkg.sv
`timescale 1ns/1ps
package par_xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_A2B,
        MODE_B2A,
        MODE_DIAG,
        MODE_ISOLATE
    } route_e;

    typedef enum logic [1:0] {
        OP_PASS,
        OP_SAMPLE,
        OP_CLEAR,
        OP_STORE
    } flag_op_e;

    typedef enum logic {
        FLAG_CLEAN,
        FLAG_TRIPPED
    } flag_state_e;
endpackage

// File: rtl/par_ctrl_decode.sv
`timescale 1ns/1ps
module par_ctrl_decode
    import par_xcvr_pkg::*;
(
    input  logic     oea_n,
    input  logic     oeb_n,
    input  logic     en_n,
    input  logic     clr_n,
    output route_e   route,
    output flag_op_e op
);
    always_comb begin
        unique case ({oea_n, oeb_n})
            2'b10:   route = MODE_A2B;
            2'b01:   route = MODE_B2A;
            2'b00:   route = MODE_DIAG;
            default: route = MODE_ISOLATE;
        endcase
    end

    always_comb begin
        unique case ({en_n, clr_n})
            2'b00:   op = OP_PASS;
            2'b01:   op = OP_SAMPLE;
            2'b10:   op = OP_CLEAR;
            default: op = OP_STORE;
        endcase
    end
endmodule

// File: rtl/par_route_path.sv
`timescale 1ns/1ps
module par_route_path
    import par_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  route_e           route,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             par_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    output logic             par_out,
    output logic             par_oe,
    output logic             chk_ok
);
    logic             a_odd;
    logic [WIDTH-1:0] b_seen;
    logic             par_seen;

    assign a_odd = ^a_in;

    always_comb begin
        a_out   = '0;
        a_oe    = '0;
        b_out   = '0;
        b_oe    = '0;
        par_out = 1'b0;
        par_oe  = 1'b0;
        unique case (route)
            MODE_A2B: begin
                b_out   = a_in;
                b_oe    = '1;
                par_out = ~a_odd;
                par_oe  = 1'b1;
            end
            MODE_B2A: begin
                a_out = b_in;
                a_oe  = '1;
            end
            MODE_DIAG: begin
                b_out   = a_in;
                b_oe    = '1;
                par_out = a_odd;
                par_oe  = 1'b1;
            end
            MODE_ISOLATE: begin
            end
        endcase
    end

    // The checker sees whatever is on the pins: own drive or far side.
    for (genvar i = 0; i < WIDTH; i++) begin : g_seen
        assign b_seen[i] = b_oe[i] ? b_out[i] : b_in[i];
    end
    assign par_seen = par_oe ? par_out : par_in;

    assign chk_ok = (route == MODE_ISOLATE) ? a_odd : ^{b_seen, par_seen};

    p_a2b_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (route == MODE_A2B) |-> ((^{b_out, par_out}) == 1'b1) && (&b_oe) && par_oe);
    p_b2a_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (route == MODE_B2A) |-> (&a_oe) && !par_oe && (b_oe == '0));
    p_diag_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (route == MODE_DIAG) |-> !chk_ok);
    p_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (route == MODE_ISOLATE) |-> (a_oe == '0) && (b_oe == '0) && !par_oe);
    p_a2b_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route == MODE_A2B) |-> chk_ok);
endmodule

// File: rtl/par_err_flag.sv
`timescale 1ns/1ps
module par_err_flag
    import par_xcvr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  flag_op_e op,
    input  logic     chk_ok,
    output logic     err_pull
);
    flag_state_e state;
    flag_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FLAG_CLEAN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (op)
            OP_PASS:   nxt = chk_ok ? FLAG_CLEAN : FLAG_TRIPPED;
            OP_SAMPLE: nxt = (state == FLAG_CLEAN && chk_ok) ? FLAG_CLEAN : FLAG_TRIPPED;
            OP_CLEAR:  nxt = FLAG_CLEAN;
            OP_STORE:  nxt = state;
        endcase
        err_pull = (nxt == FLAG_TRIPPED);
    end

    p_pass_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PASS) |-> (err_pull != chk_ok));
    p_sample_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && op == OP_SAMPLE && $past(op) == OP_SAMPLE && $past(err_pull)) |-> err_pull);
    p_clear_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_CLEAR && op == OP_STORE) |-> !err_pull);
    p_store_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && op == OP_STORE) |-> $stable(err_pull));
endmodule

// File: rtl/par_xcvr.sv
`timescale 1ns/1ps
module par_xcvr
    import par_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oea_n,
    input  logic             oeb_n,
    input  logic             en_n,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_pull
);
    route_e   route;
    flag_op_e op;
    logic     chk_ok;

    par_ctrl_decode u_dec (
        .oea_n (oea_n),
        .oeb_n (oeb_n),
        .en_n  (en_n),
        .clr_n (clr_n),
        .route (route),
        .op    (op)
    );

    par_route_path #(.WIDTH(WIDTH)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .route   (route),
        .a_in    (a_in),
        .b_in    (b_in),
        .par_in  (par_in),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .par_out (par_out),
        .par_oe  (par_oe),
        .chk_ok  (chk_ok)
    );

    par_err_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .chk_ok   (chk_ok),
        .err_pull (err_pull)
    );

    p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)) && (!par_oe || (&b_oe)));
    p_reset_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && en_n && clr_n) |-> !err_pull);
endmodule

// File: tb/sim_par_xcvr.sv
`timescale 1ns/1ps
module sim_par_xcvr;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         oea_n = 1'b1, oeb_n = 1'b1, en_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         par_in = 1'b0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         par_out, par_oe, err_pull;

    int checks = 0;
    int fails  = 0;
    int model_flag = 1;   // 1 = no error shown

    always #10 clk = ~clk;

    par_xcvr #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .oea_n(oea_n), .oeb_n(oeb_n),
        .en_n(en_n), .clr_n(clr_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .err_pull(err_pull)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string route_tag(input logic oa, input logic ob);
        if (oa && !ob) return "R1";
        if (!oa && ob) return "R2";
        if (!oa && !ob) return "R3";
        return "R4";
    endfunction

    function automatic string op_tag(input logic e, input logic c);
        if (!e && !c) return "R6 R5";
        if (!e && c)  return "R7 R5";
        if (e && !c)  return "R8";
        return "R9";
    endfunction

    // One cycle: apply inputs, compare against the model, advance the model.
    task automatic cycle(input logic oa, input logic ob, input logic e, input logic c,
                         input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                         input logic rs);
        logic [W-1:0] ea_oe, eb_oe, ea_out, eb_out;
        logic         ep_oe, ep_out, bus_ok;
        int           ones, lvl;
        @(negedge clk);
        oea_n = oa; oeb_n = ob; en_n = e; clr_n = c;
        a_in = a; b_in = b; par_in = p; rst_n = rs;
        #5;
        ea_oe = '0; eb_oe = '0; ea_out = '0; eb_out = '0; ep_oe = 0; ep_out = 0;
        if (oa && !ob) begin
            eb_oe = '1; eb_out = a; ep_oe = 1; ep_out = ($countones(a) % 2 == 0);
        end else if (!oa && ob) begin
            ea_oe = '1; ea_out = b;
        end else if (!oa && !ob) begin
            eb_oe = '1; eb_out = a; ep_oe = 1; ep_out = ($countones(a) % 2 == 1);
        end
        check(route_tag(oa, ob),
              {22'd0, a_oe, b_oe, par_oe, a_out & a_oe, b_out & b_oe, par_out & par_oe},
              {22'd0, ea_oe, eb_oe, ep_oe, ea_out, eb_out, ep_out});
        check("R11", {63'd0, !((|a_oe) && (|b_oe)) && (!par_oe || (&b_oe))}, 64'd1);
        // check node from the pins seen
        if (oa && ob) ones = $countones(a);
        else if (ob == 1'b0) ones = $countones(a) + (ep_out ? 1 : 0);
        else ones = $countones(b) + (p ? 1 : 0);
        bus_ok = (ones % 2 == 1);
        if (!e && !c)      lvl = bus_ok ? 1 : 0;
        else if (!e && c)  lvl = (model_flag == 1 && bus_ok) ? 1 : 0;
        else if (e && !c)  lvl = 1;
        else               lvl = model_flag;
        if (rs) check(op_tag(e, c), {63'd0, err_pull}, {63'd0, (lvl == 0)});
        @(posedge clk);
        #1;
        model_flag = rs ? lvl : 1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // reset, then store: flag must show clean (R10)
        for (int i = 0; i < 3; i++) cycle(1, 1, 1, 1, 8'h00, 8'h00, 0, 0);
        @(negedge clk); en_n = 1; clr_n = 1; rst_n = 1; #5;
        check("R10", {63'd0, err_pull}, 64'd0);
        // sticky sample sequence in B2A
        cycle(0, 1, 0, 1, 8'h01, 8'h01, 0, 1);  // good
        cycle(0, 1, 0, 1, 8'h01, 8'h03, 0, 1);  // bad: trips
        cycle(0, 1, 0, 1, 8'h01, 8'h07, 0, 1);  // good again, stays tripped R7
        cycle(0, 1, 1, 1, 8'h01, 8'h07, 0, 1);  // store holds R9
        cycle(0, 1, 1, 0, 8'h01, 8'h07, 0, 1);  // clear R8
        cycle(0, 1, 1, 1, 8'h01, 8'h03, 0, 1);  // store clean
        cycle(0, 1, 0, 0, 8'h01, 8'h03, 1, 1);  // pass good R6
        cycle(0, 1, 0, 0, 8'h01, 8'h03, 0, 1);  // pass bad R6
        cycle(1, 0, 0, 0, 8'h5A, 8'h00, 0, 1);  // A2B pass R1
        cycle(0, 0, 0, 0, 8'h5A, 8'h00, 0, 1);  // DIAG fails R3
        cycle(0, 0, 0, 0, 8'h5B, 8'h00, 0, 1);
        cycle(1, 1, 0, 0, 8'h07, 8'h00, 0, 1);  // isolate odd A R4
        cycle(1, 1, 0, 0, 8'h03, 8'h00, 0, 1);  // isolate even A
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0], r[1], r[2] & r[3], r[4] | r[5], r[15:8], r[23:16], r[24],
                  (i == 1500) ? 1'b0 : 1'b1);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule